// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front-End

This block is the slave end of a two-wire serial memory link. It oversamples the clock and data lines on the system clock, finds start and stop conditions, and shifts in a slave byte. A fixed device-type code, a fixed zero bit and two strapped select bits are compared with that byte. On a match the block acknowledges by pulling the data line low. Memory accesses then go through a simple synchronous port: the read data is valid one clock after the read strobe.

A write transfer carries a 16-bit word address, high byte first, and then any number of data bytes. Each data byte is written to the next location. A read transfer sends bytes from an internal address counter for as long as the master acknowledges them. Reads can follow a completed write, or follow a pair of address bytes cut short by a repeated start. The line output is open-drain and is modelled as a pull-down enable. The host combines it with the master's drive to form the wired bus level.

Top module: `i2c_mem_slave`

## Requirements
- R1: The slave byte is checked MSB first as bits [7:4] = 4'b1010, bit 3 = 0, bits [2:1] = sel_i, bit 0 = read (1) / write (0). On a match, sda_pd_o is asserted for the whole ninth clock. sda_pd_o only changes after a falling SCL edge.
- R2: If the slave byte does not match, no acknowledge is given. The block then does no memory access and drives nothing until the next start condition. A start always releases the line.
- R3: In a write transfer, the two bytes after the slave byte form the word address, high byte (A15..A8) first. Each of them is acknowledged.
- R4: Each data byte after the word address is acknowledged and written with a single-cycle mem_we_o pulse. The first goes to the loaded address and later ones to consecutive addresses. mem_we_o and mem_re_o are never high together.
- R5: A read transfer starts at the current counter value. The counter is not reloaded. Data bits are driven MSB first on the line.
- R6: In a read, the counter increases by one after every byte sent. The next byte follows as long as the master acknowledges.
- R7: A master NACK ends the read, and the line stays released from then on. A stop condition returns the block to idle with the line released.
- R8: The address counter wraps from 16'hFFFF to 16'h0000, for writes and for reads alike.
- R9: While rst_ni is low the line is released and any transfer is dropped. The counter returns to 16'h0000.
- R10: Two address bytes followed by a repeated start and a read slave byte give a read from the address just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| sel_i | input | 2 | Device-select straps |
| sda_pd_o | output | 1 | Pull-down enable for the data line |
| mem_addr_o | output | 16 | Memory address (current counter) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid the cycle after mem_re_o |

## Verification
Some rules can be checked on every cycle, and the assertions cover them. The pull-down may only change after a falling clock edge. Start and stop must always release the line. Write strobes are single pulses and never overlap a read. Every counter step is exactly plus one modulo 2^16, which covers the wrap. Other behaviour needs whole transfers, so only the bench scenarios can show it. These are select mismatches, the high-first address order, write addresses and data, random, current-address and sequential reads, release after a NACK, the wrap, and abandoning a transfer on reset.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } state_e;

  // what the byte being received means
  typedef enum logic [1:0] {
    K_DEV, K_AHI, K_ALO, K_DATA
  } kind_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // stage chain, idle-high reset
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else if (g == 0) begin
        scl_ff[g] <= scl_i;
        sda_ff[g] <= sda_i;
      end else begin
        scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
        sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr
  import i2c_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= q_o + 1'b1;  // natural wrap
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              sda_pd_o,
  output logic              ctr_load_o,
  output logic [ADDR_W-1:0] ctr_val_o,
  output logic              ctr_inc_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(DATA_W - 1);

  state_e            state_q;
  kind_e             kind_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh, tx_buf, addr_hi;
  logic              ack_q, rw_q, rd_pend, m_ack;
  logic              dev_match;

  assign dev_match = (rx_sh[7:1] == {DEV_ID, 1'b0, sel_i});
  assign ctr_val_o = {addr_hi, rx_sh};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_DEV;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      tx_buf      <= '0;
      addr_hi     <= '0;
      ack_q       <= 1'b0;
      rw_q        <= 1'b0;
      rd_pend     <= 1'b0;
      m_ack       <= 1'b0;
      sda_pd_o    <= 1'b0;
      ctr_load_o  <= 1'b0;
      ctr_inc_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
      mem_re_o    <= 1'b0;
    end else begin
      mem_we_o   <= 1'b0;
      mem_re_o   <= 1'b0;
      ctr_load_o <= 1'b0;
      ctr_inc_o  <= 1'b0;
      rd_pend    <= mem_re_o;
      if (rd_pend) tx_buf <= mem_rdata_i;

      if (start_i) begin
        state_q  <= ST_RX;
        kind_q   <= K_DEV;
        bit_cnt  <= '0;
        sda_pd_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_pd_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_RX: begin
            if (scl_rise_i) begin
              rx_sh   <= {rx_sh[DATA_W-2:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall_i && bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              state_q <= ST_ACK;
              ack_q   <= 1'b1;
              sda_pd_o <= 1'b1;
              unique case (kind_q)
                K_DEV: begin
                  if (dev_match) begin
                    rw_q     <= rx_sh[0];
                    mem_re_o <= rx_sh[0];
                  end else begin
                    ack_q    <= 1'b0;
                    sda_pd_o <= 1'b0;
                  end
                end
                K_AHI:  addr_hi <= rx_sh;
                K_ALO:  ctr_load_o <= 1'b1;
                K_DATA: begin
                  mem_we_o    <= 1'b1;
                  mem_wdata_o <= rx_sh;
                end
                default: ;
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_pd_o <= 1'b0;
              if (!ack_q) begin
                state_q <= ST_IDLE;  // foreign device: nine clocks, then idle
              end else begin
                state_q <= ST_RX;
                unique case (kind_q)
                  K_DEV: begin
                    if (rw_q) begin
                      state_q  <= ST_TX;
                      tx_sh    <= tx_buf;
                      sda_pd_o <= ~tx_buf[DATA_W-1];
                    end else begin
                      kind_q <= K_AHI;
                    end
                  end
                  K_AHI:  kind_q <= K_ALO;
                  K_ALO:  kind_q <= K_DATA;
                  K_DATA: ctr_inc_o <= 1'b1;
                  default: ;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_TX) begin
                state_q   <= ST_MACK;
                sda_pd_o  <= 1'b0;
                ctr_inc_o <= 1'b1;
                bit_cnt   <= '0;
              end else begin
                tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
                sda_pd_o <= ~tx_sh[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise_i) begin
              m_ack    <= ~sda_i;
              mem_re_o <= 1'b1;  // prefetch at advanced counter
            end
            if (scl_fall_i) begin
              if (m_ack) begin
                state_q  <= ST_TX;
                tx_sh    <= tx_buf;
                sda_pd_o <= ~tx_buf[DATA_W-1];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        sel_i,
  output logic              sda_pd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ctr_load, ctr_inc;
  logic [ADDR_W-1:0] ctr_val;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slave_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sel_i       (sel_i),
    .mem_rdata_i (mem_rdata_i),
    .sda_pd_o    (sda_pd_o),
    .ctr_load_o  (ctr_load),
    .ctr_val_o   (ctr_val),
    .ctr_inc_o   (ctr_inc),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_re_o    (mem_re_o)
  );

  i2c_addr_ctr u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (ctr_val),
    .inc_i      (ctr_inc),
    .q_o        (mem_addr_o)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input logic              ctr_load,
  input logic              ctr_inc,
  input logic              sda_pd_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  p_we_re_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  p_we_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  p_pd_on_fall_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd_o) |-> $past(scl_fall));

  p_stop_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pd_o);

  p_start_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_pd_o);

  p_ctr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctr_inc && !ctr_load) |=> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall   (scl_fall),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .ctr_load   (ctr_load),
  .ctr_inc    (ctr_inc),
  .sda_pd_o   (sda_pd_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/i2c_mem_slave_tb.sv
`timescale 1ns/1ps
module i2c_mem_slave_tb;
  localparam int Q = 80;  // quarter SCL period
  localparam logic [1:0] SEL = 2'b10;
  localparam logic [7:0] DEV_W = {4'b1010, 1'b0, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, 1'b0, SEL, 1'b1};

  logic clk = 1'b0, rst_ni = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_pd, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_pd;

  always #4 clk = ~clk;

  i2c_mem_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_bus), .sel_i(SEL),
    .sda_pd_o(sda_pd), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_re_o(mem_re), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem [256];
  logic [7:0] ref_m [256];
  logic [15:0] wlog_a [16];
  logic [7:0]  wlog_d [16];
  int wcnt = 0;
  int n_chk = 0, n_fail = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i) ^ 8'hA5;
      ref_m[i] = 8'(i) ^ 8'hA5;
    end
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wlog_a[wcnt % 16] <= mem_addr;
      wlog_d[wcnt % 16] <= mem_wdata;
      wcnt <= wcnt + 1;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    #Q sda_m = 1'b0;
    #Q scl = 1'b0;
  endtask

  task automatic i2c_rstart();
    #Q sda_m = 1'b1;
    #Q scl = 1'b1;
    #Q sda_m = 1'b0;
    #Q scl = 1'b0;
  endtask

  task automatic i2c_stop();
    #Q sda_m = 1'b0;
    #Q scl = 1'b1;
    #Q sda_m = 1'b1;
    #Q;
  endtask

  task automatic send_bit(input logic b);
    #Q sda_m = b;
    #Q scl = 1'b1;
    #(2*Q) scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    #Q sda_m = 1'b1;
    #Q scl = 1'b1;
    #Q ack = (sda_bus == 1'b0);
    #Q scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      #Q sda_m = 1'b1;
      #Q scl = 1'b1;
      #Q b[i] = sda_bus;
      #Q scl = 1'b0;
    end
    send_bit(~mack);
  endtask

  task automatic t_reset_state();
    chk("R9 pd after reset", 32'(sda_pd), 0);
    chk("R9 we after reset", 32'(mem_we), 0);
    chk("R9 re after reset", 32'(mem_re), 0);
  endtask

  task automatic t_read_from_zero();
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(DEV_R, a);
    chk("R1 ack on read slave byte", 32'(a), 1);
    recv_byte(1'b0, d);
    chk("R5 R9 first read at 0000", 32'(d), 32'(ref_m[8'h00]));
    i2c_stop();
  endtask

  task automatic t_mismatch();
    logic a; int w0 = wcnt;
    i2c_start();
    send_byte({4'b1010, 1'b0, ~SEL, 1'b0}, a);
    chk("R2 no ack wrong select", 32'(a), 0);
    send_byte(8'h12, a);
    chk("R2 later byte ignored", 32'(a), 0);
    send_byte(8'h34, a);
    chk("R2 later byte ignored 2", 32'(a), 0);
    i2c_stop();
    i2c_start();
    send_byte({4'b1010, 1'b1, SEL, 1'b0}, a);
    chk("R1 R2 no ack fixed bit 1", 32'(a), 0);
    send_byte(8'h77, a);
    chk("R2 data after bad fixed bit", 32'(a), 0);
    i2c_stop();
    chk("R2 no write on mismatch", wcnt - w0, 0);
  endtask

  task automatic do_write(input logic [15:0] ad, input logic [7:0] d0, input logic [7:0] d1,
                          input string tag);
    logic a; int w0 = wcnt;
    i2c_start();
    send_byte(DEV_W, a);
    chk({tag, " R1 ack slave"}, 32'(a), 1);
    send_byte(ad[15:8], a);
    chk({tag, " R3 ack hi"}, 32'(a), 1);
    send_byte(ad[7:0], a);
    chk({tag, " R3 ack lo"}, 32'(a), 1);
    send_byte(d0, a);
    chk({tag, " R4 ack d0"}, 32'(a), 1);
    send_byte(d1, a);
    chk({tag, " R4 ack d1"}, 32'(a), 1);
    i2c_stop();
    #Q;
    chk({tag, " R4 write count"}, wcnt - w0, 2);
    chk({tag, " R3 first addr"}, 32'(wlog_a[w0 % 16]), 32'(ad));
    chk({tag, " R4 R8 next addr"}, 32'(wlog_a[(w0 + 1) % 16]), 32'(16'(ad + 16'd1)));
    chk({tag, " R4 data0"}, 32'(wlog_d[w0 % 16]), 32'(d0));
    chk({tag, " R4 data1"}, 32'(wlog_d[(w0 + 1) % 16]), 32'(d1));
    ref_m[ad[7:0]] = d0;
    ref_m[8'(ad[7:0] + 8'd1)] = d1;
  endtask

  task automatic rand_read(input logic [15:0] ad, input int n, input string tag);
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(DEV_W, a);
    send_byte(ad[15:8], a);
    send_byte(ad[7:0], a);
    i2c_rstart();
    send_byte(DEV_R, a);
    chk({tag, " R10 ack after repeated start"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({tag, " R6 R10 seq byte"}, 32'(d), 32'(ref_m[8'(ad[7:0] + 8'(i))]));
    end
    i2c_stop();
  endtask

  task automatic t_cur_read_nack();
    logic a; logic [7:0] d;
    i2c_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, d);
    chk("R5 current address read", 32'(d), 32'(ref_m[8'h37]));
    // extra clock after NACK: slave must stay off the line
    #Q sda_m = 1'b1;
    #Q scl = 1'b1;
    #Q chk("R7 released after NACK", 32'(sda_bus), 1);
    #Q scl = 1'b0;
    i2c_stop();
    chk("R7 idle after stop", 32'(sda_pd), 0);
  endtask

  task automatic t_reset_mid();
    logic a; logic [7:0] d; int w0 = wcnt;
    i2c_start();
    send_byte(DEV_W, a);
    send_byte(8'h00, a);
    send_byte(8'h40, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    rst_ni = 1'b0;
    #Q chk("R9 line released in reset", 32'(sda_pd), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    i2c_stop();
    chk("R9 aborted transfer wrote nothing", wcnt - w0, 0);
    i2c_start();
    send_byte(DEV_R, a);
    recv_byte(1'b0, d);
    chk("R9 counter back to 0000", 32'(d), 32'(ref_m[8'h00]));
    i2c_stop();
  endtask

  initial begin
    #96 rst_ni = 1'b1;
    #160;
    t_reset_state();
    t_read_from_zero();
    t_mismatch();
    do_write(16'h1234, 8'h11, 8'h22, "wr1");
    rand_read(16'h1234, 3, "rr1");
    t_cur_read_nack();
    do_write(16'hFFFF, 8'hC3, 8'h3C, "wrap R8");
    rand_read(16'hFFFF, 2, "wrap R8");
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule